// File: doc/BRIEF.md
# Column-Count Serial Accumulator

This block sums a job of M unsigned N-bit words that arrive one per clock. It does not keep a running binary total. Each bit position instead has its own small counter. The counter steps up by one whenever a word is taken and that word has a 1 in that position. When the last word of the job has been counted, each column count is shifted to the weight of its column, the shifted counts are added once, and the total is placed in a result register.

A job starts with a one-cycle start pulse. The pulse clears every column counter and opens the block to accept words. Words are offered with a valid strobe and may come with idle cycles between them. After M words have been taken, the block ignores further words until the next start. It raises a one-cycle done pulse together with the new total, and the total then holds until the next job finishes.

Top module: `colacc_top`

## Requirements
- R1: After reset, done_o is low and sum_o is zero.
- R2: A start pulse clears every column count and the word tally. A job cut short by a new start adds nothing to the next total.
- R3: The counter for column j (bit j of operand_i, bit 0 the least significant) grows by one only on a clock edge where a word is taken and bit j of that word is 1. Its count goes into the total at weight 2^j.
- R4: sum_o equals the unsigned sum of the M taken words. It is N + ceil(log2(M+1)) bits wide and never overflows, even when every word is all ones.
- R5: Let the M-th word of a job be taken at clock edge k. Then done_o is high for exactly the one cycle after edge k+1, and sum_o carries the new total from that same edge.
- R6: Cycles with valid_i low take no word, so idle gaps inside a job do not change the total.
- R7: Words offered while no job is open are ignored and leave sum_o unchanged. This covers words after reset before any start, and words after the M-th word of a job.
- R8: A word offered in the same cycle as start_i is discarded.
- R9: With N = 8 and M = 7, the words 0xB1, 0x01, 0xCD, 0xE3, 0x71, 0xCD and 0x8D give a total of 1069.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that clears the counts and opens a job |
| valid_i | input | 1 | operand_i carries a word this cycle |
| operand_i | input | N | Unsigned word to accumulate |
| done_o | output | 1 | One-cycle pulse: sum_o has the new total |
| sum_o | output | N+ceil(log2(M+1)) | Total of the last finished job |

## Verification
The bench feeds all-ones words to find a result bus that is too narrow or a counter that wraps at M; a narrow design would give a small, wrapped total. It feeds words that set only the top bit or only the bottom bit to find a column placed at the wrong weight, which would shift the total by a power of two. It puts gaps inside jobs, offers words outside any job, and offers a word in the same cycle as start. A design that counts regardless of valid, or lets start and a word collide, would give a total that is too large or would raise done too early. It also aborts a job with a new start, which shows up any count that survives the clear, and it checks the exact cycle of the done pulse against the edge on which the last word was taken.

// File: rtl/colacc_pkg.sv
package colacc_pkg;
  typedef enum logic [1:0] {
    JOB_IDLE  = 2'd0,
    JOB_RUN   = 2'd1,
    JOB_FLUSH = 2'd2
  } job_state_e;
endpackage

// File: rtl/colacc_column_ctr.sv
module colacc_column_ctr #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic          bit_in,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (clr)              count <= '0;
    else if (take && bit_in)   count <= count + CW'(1);
  end
endmodule

// File: rtl/colacc_weighted_sum.sv
module colacc_weighted_sum #(
  parameter int N  = 8,
  parameter int CW = 3
) (
  input  logic [N*CW-1:0]   counts,
  output logic [N+CW-1:0]   total
);
  localparam int RW = N + CW;

  function automatic logic [RW-1:0] place(input logic [CW-1:0] c, input int col);
    return RW'(c) << col;
  endfunction

  always_comb begin
    total = '0;
    for (int j = 0; j < N; j++) begin
      total = total + place(counts[j*CW +: CW], j);
    end
  end
endmodule

// File: rtl/colacc_seq.sv
module colacc_seq
  import colacc_pkg::*;
#(
  parameter int M  = 7,
  parameter int CW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic valid,
  output logic take,
  output logic fin
);
  job_state_e      state;
  logic [CW-1:0]   tally;
  logic            last_word;

  assign take      = (state == JOB_RUN) && valid && !start;
  assign last_word = (tally == CW'(M - 1));
  assign fin       = (state == JOB_FLUSH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= JOB_IDLE;
      tally <= '0;
    end else if (start) begin
      state <= JOB_RUN;
      tally <= '0;
    end else begin
      case (state)
        JOB_RUN: if (take) begin
          if (last_word) state <= JOB_FLUSH;
          else           tally <= tally + CW'(1);
        end
        JOB_FLUSH: state <= JOB_IDLE;
        default:   state <= JOB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/colacc_top.sv
module colacc_top #(
  parameter int N = 8,
  parameter int M = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         valid_i,
  input  logic [N-1:0]                 operand_i,
  output logic                         done_o,
  output logic [N+$clog2(M+1)-1:0]     sum_o
);
  localparam int CW = $clog2(M + 1);
  localparam int RW = N + CW;

  logic            accept;
  logic            fin;
  logic [N*CW-1:0] col_counts;
  logic [RW-1:0]   wsum;

  colacc_seq #(.M(M), .CW(CW)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_i),
    .valid (valid_i),
    .take  (accept),
    .fin   (fin)
  );

  for (genvar j = 0; j < N; j++) begin : g_col
    colacc_column_ctr #(.CW(CW)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (start_i),
      .take   (accept),
      .bit_in (operand_i[j]),
      .count  (col_counts[j*CW +: CW])
    );
  end

  colacc_weighted_sum #(.N(N), .CW(CW)) u_wsum (
    .counts (col_counts),
    .total  (wsum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      sum_o  <= '0;
    end else begin
      done_o <= fin;
      if (fin) sum_o <= wsum;
    end
  end
endmodule

// File: rtl/colacc_chk.sv
module colacc_chk #(
  parameter int N = 8,
  parameter int M = 7
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start_i,
  input logic                       accept,
  input logic [N-1:0]               operand_i,
  input logic [N*$clog2(M+1)-1:0]   col_counts,
  input logic                       done_o,
  input logic [N+$clog2(M+1)-1:0]   sum_o
);
  localparam int CW = $clog2(M + 1);
  localparam int RW = N + CW;

  logic [RW-1:0] ref_sum;
  logic [CW:0]   ref_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sum <= '0;
      ref_cnt <= '0;
    end else if (start_i) begin
      ref_sum <= '0;
      ref_cnt <= '0;
    end else if (accept) begin
      ref_sum <= ref_sum + RW'(operand_i);
      ref_cnt <= ref_cnt + 1'b1;
    end
  end

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !done_o);

  // R4
  p_sum_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(start_i)) |-> (sum_o == ref_sum));

  // R5
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_after_m_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(start_i)) |-> (ref_cnt == (CW+1)'(M)));

  p_sum_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(sum_o));

  // R6
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !start_i) |=> $stable(col_counts));

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (col_counts == '0));

  for (genvar j = 0; j < N; j++) begin : g_step
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !(accept && operand_i[j])) |=> $stable(col_counts[j*CW +: CW]));
  end
endmodule

bind colacc_top colacc_chk #(.N(N), .M(M)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .accept     (accept),
  .operand_i  (operand_i),
  .col_counts (col_counts),
  .done_o     (done_o),
  .sum_o      (sum_o)
);

// File: tb/tb_colacc_top.sv
module tb_colacc_top;
  localparam int N  = 8;
  localparam int M  = 7;
  localparam int CW = $clog2(M + 1);
  localparam int RW = N + CW;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          valid_i = 1'b0;
  logic [N-1:0]  operand_i = '0;
  logic          done_o;
  logic [RW-1:0] sum_o;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_q[$];
  string tag_q[$];

  colacc_top #(.N(N), .M(M)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
    .operand_i(operand_i), .done_o(done_o), .sum_o(sum_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  // monitor: pops expected totals as done pulses appear
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected done", 1, 0);
      end else begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(sum_o == RW'(e), t, sum_o, e);
      end
    end
  end

  // driver: start, words (with optional gaps), and done timing (R5)
  task automatic run_job(input logic [N-1:0] ops[], input bit gaps, input string req);
    automatic int total = 0;
    foreach (ops[i]) total += int'(ops[i]);
    exp_q.push_back(total);
    tag_q.push_back(req);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < ops.size(); i++) begin
      if (gaps && ($urandom_range(0, 1) == 1)) begin
        valid_i = 1'b0;
        operand_i = N'($urandom);
        @(negedge clk);
      end
      valid_i = 1'b1;
      operand_i = ops[i];
      @(negedge clk);
    end
    valid_i = 1'b0;
    chk(done_o == 1'b0, "R5 done early", done_o, 0);
    @(negedge clk);
    chk(done_o == 1'b1, "R5 done missing", done_o, 1);
    @(negedge clk);
    chk(done_o == 1'b0, "R5 done too long", done_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [N-1:0] ops[];
    logic [RW-1:0] held;
    ops = new[M];

    repeat (3) @(negedge clk);
    // R1
    chk(done_o == 1'b0, "R1 done", done_o, 0);
    chk(sum_o == '0, "R1 sum", sum_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: words before any start are ignored
    for (int i = 0; i < 4; i++) begin
      valid_i = 1'b1; operand_i = 8'hFF; @(negedge clk);
    end
    valid_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(sum_o == '0, "R7 pre-start sum", sum_o, 0);

    // R9: the given seven words
    ops = '{8'hB1, 8'h01, 8'hCD, 8'hE3, 8'h71, 8'hCD, 8'h8D};
    run_job(ops, 1'b0, "R9 example");
    chk(sum_o == RW'(1069), "R9 total", sum_o, 1069);

    // R4: all ones, widest total
    foreach (ops[i]) ops[i] = '1;
    run_job(ops, 1'b0, "R4 all ones");
    chk(sum_o == RW'(M * 255), "R4 all ones total", sum_o, M * 255);

    // R4: all zeros
    foreach (ops[i]) ops[i] = '0;
    run_job(ops, 1'b0, "R4 all zeros");

    // R3: single top column, single bottom column
    foreach (ops[i]) ops[i] = 8'h80;
    run_job(ops, 1'b0, "R3 top column");
    foreach (ops[i]) ops[i] = 8'h01;
    run_job(ops, 1'b0, "R3 bottom column");

    // R6: random jobs with idle gaps
    for (int r = 0; r < 12; r++) begin
      foreach (ops[i]) ops[i] = N'($urandom);
      run_job(ops, 1'b1, "R6 random gapped");
    end

    // R7: words after the M-th word are ignored
    held = sum_o;
    for (int i = 0; i < 5; i++) begin
      valid_i = 1'b1; operand_i = N'($urandom | 1); @(negedge clk);
    end
    valid_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(sum_o == held, "R7 post-job hold", sum_o, held);

    // R2: aborted job adds nothing
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      valid_i = 1'b1; operand_i = 8'hFF; @(negedge clk);
    end
    valid_i = 1'b0;
    foreach (ops[i]) ops[i] = N'(i + 1);
    run_job(ops, 1'b0, "R2 restart");

    // R8: word alongside start is dropped
    @(negedge clk); start_i = 1'b1; valid_i = 1'b1; operand_i = 8'hFF;
    @(negedge clk); start_i = 1'b0; valid_i = 1'b0;
    foreach (ops[i]) ops[i] = 8'h10;
    run_job(ops, 1'b0, "R8 start collision");
    chk(sum_o == RW'(M * 16), "R8 total", sum_o, M * 16);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 missing done", exp_q.size(), 0);
    finish_run();
  end
endmodule